// File: doc/BRIEF.md
# Write-Order-Selected Arithmetic Coprocessor

This block is a small arithmetic helper that sits beside a host on a byte-wide register port. It holds six operand bytes and one control byte. It has no opcode register. The host chooses the operation by the order in which it writes the operand bytes. The write that completes a legal order launches the job. The job runs for a fixed number of cycles while the host goes on with other work. The results then overwrite the operand bytes, and a completion flag rises.

Four jobs are available:
- division of a 32-bit value by a 16-bit value;
- division of a 16-bit value by a 16-bit value;
- a 16-by-16 product;
- a 32-bit shift by a programmed count.

A shift count of zero turns the shift into a normalize. A normalize moves the operand left until its top bit is set, and the number of positions moved is written back into the count field. Any write that does not fit the order in progress drops the decoder back to idle.

Top module: `seqsel_mdu`

## Requirements
- R1: After reset, all six operand bytes and the control byte read as zero, and `busy` and `done` are low.
- R2: Addresses 0 to 5 select operand bytes B0 to B5 and address 6 selects the control byte. In the control byte, bit 5 is the direction (0 = left, 1 = right) and bits 4:0 are the count; bits 7:6 read as zero. `rd_data` shows the register at `rd_addr` one clock edge later. A write while idle stores its byte even when it starts nothing.
- R3: The order B0, B1, B2, B3, B4, B5 starts a 32/16 division of {B3..B0} by {B5,B4}, launched by the B5 write. The quotient lands in B3..B0 and the remainder in B5,B4. `done` rises 17 edges after the launching write.
- R4: The order B0, B1, B4, B5 starts a 16/16 division of {B1,B0} by {B5,B4}. The quotient lands in B1,B0, B3 and B2 become zero, and the remainder lands in B5,B4. `done` rises 9 edges after the launch.
- R5: The order B0, B4, B1, B5 starts the product {B1,B0} × {B5,B4}. The 32-bit product lands in B3..B0 and B5,B4 keep the multiplier. `done` rises 11 edges after the launch.
- R6: The order B0, B1, B2, B3, then a control write with a nonzero count n, shifts {B3..B0} logically by n positions in the chosen direction. The result lands in B3..B0 and `done` rises 3 + floor((n-1)/2) edges after the control write.
- R7: The same order with a count of zero performs a normalize, whatever the direction bit. The operand shifts left until bit 31 is 1, or not at all if it is zero. The number of shifts k is written to the count field, and `done` rises 4 + floor(k/2) edges after the launch.
- R8: The launching edge clears `done` and sets `busy`. The completing edge clears `busy`, sets `done` and writes the results. `busy` and `done` are never high together.
- R9: A write that does not continue the order in progress returns the decoder to idle, so a later tail of writes starts nothing. A write to B0 always begins a fresh order. A control write starts a job only directly after B0..B3.
- R10: Writes made while `busy` is high change no register and do not advance the decoder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Write address (0-5 operand bytes, 6 control) |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | A job is running |
| done | output | 1 | Completion flag, cleared by the next launch |

## Verification
Each result is due a fixed number of edges after the write that launches it. Division takes 17 or 9 edges and the product takes 11. A shift takes 3 + floor((n-1)/2) edges and a normalize takes 4 + floor(k/2). The bench records the cycle number at the falling edge after the launching write. The monitor then notes the cycle at which `done` is first seen high and requires it to equal the start plus the computed latency. Readback needs one extra edge, because `rd_data` is registered. So every read sets the address at a falling edge and samples at the next falling edge.

// File: rtl/seqsel_mdu_pkg.sv
package seqsel_mdu_pkg;
  typedef enum logic [1:0] {OP_DIV32, OP_DIV16, OP_MUL, OP_SHIFT} mdu_op_e;

  localparam int ADDR_W    = 3;
  localparam int NUM_OPB   = 6;
  localparam int CTRL_ADDR = 6;
  localparam int LAT_DIV32 = 17;
  localparam int LAT_DIV16 = 9;
  localparam int LAT_MUL   = 11;
  localparam int LAT_SHIFT = 3;
  localparam int LAT_NORM  = 4;
  localparam int LAT_W     = 5;
endpackage

// File: rtl/seqsel_mdu_decoder.sv
module seqsel_mdu_decoder
  import seqsel_mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              start,
  output mdu_op_e           op
);
  typedef enum logic [3:0] {
    D_IDLE, D_B0, D_B01, D_B012, D_B0123, D_B01234, D_B014, D_B04, D_B041
  } dec_state_e;

  dec_state_e state_q, state_nx;

  always_comb begin
    state_nx = state_q;
    start    = 1'b0;
    op       = OP_DIV32;
    if (wr_ok) begin
      if (wr_addr == ADDR_W'(0)) begin
        state_nx = D_B0;
      end else begin
        state_nx = D_IDLE;
        case (state_q)
          D_B0:     if (wr_addr == ADDR_W'(1)) state_nx = D_B01;
                    else if (wr_addr == ADDR_W'(4)) state_nx = D_B04;
          D_B01:    if (wr_addr == ADDR_W'(2)) state_nx = D_B012;
                    else if (wr_addr == ADDR_W'(4)) state_nx = D_B014;
          D_B012:   if (wr_addr == ADDR_W'(3)) state_nx = D_B0123;
          D_B0123:  if (wr_addr == ADDR_W'(4)) state_nx = D_B01234;
                    else if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
                      start = 1'b1;
                      op    = OP_SHIFT;
                    end
          D_B01234: if (wr_addr == ADDR_W'(5)) begin
                      start = 1'b1;
                      op    = OP_DIV32;
                    end
          D_B014:   if (wr_addr == ADDR_W'(5)) begin
                      start = 1'b1;
                      op    = OP_DIV16;
                    end
          D_B04:    if (wr_addr == ADDR_W'(1)) state_nx = D_B041;
          D_B041:   if (wr_addr == ADDR_W'(5)) begin
                      start = 1'b1;
                      op    = OP_MUL;
                    end
          default:  state_nx = D_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= D_IDLE;
    else     state_q <= state_nx;
  end
endmodule

// File: rtl/seqsel_mdu_engine.sv
module seqsel_mdu_engine
  import seqsel_mdu_pkg::*;
#(
  parameter int STEPS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  mdu_op_e     op,
  input  logic [31:0] opa,
  input  logic [15:0] opb,
  output logic [31:0] res_lo,
  output logic [15:0] res_hi
);
  localparam int IT_W     = 6;
  localparam int IT_DIV32 = 32 / STEPS;
  localparam int IT_HALF  = 16 / STEPS;

  logic [31:0]   acc_q;
  logic [15:0]   rem_q, den_q;
  logic [IT_W-1:0] iters_q;
  logic          mul_q, half_q;
  logic [31:0]   acc_n;
  logic [15:0]   rem_n;

  always_comb begin
    logic [16:0] trial, msum;
    acc_n = acc_q;
    rem_n = rem_q;
    for (int k = 0; k < STEPS; k++) begin
      trial = {rem_n, acc_n[31]};
      msum  = {1'b0, acc_n[31:16]} + (acc_n[0] ? {1'b0, den_q} : 17'd0);
      if (mul_q) begin
        acc_n = {msum, acc_n[15:1]};
      end else if (trial >= {1'b0, den_q}) begin
        rem_n = 16'(trial - {1'b0, den_q});
        acc_n = {acc_n[30:0], 1'b1};
      end else begin
        rem_n = trial[15:0];
        acc_n = {acc_n[30:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      iters_q <= '0;
      mul_q   <= 1'b0;
      half_q  <= 1'b0;
    end else if (load) begin
      rem_q  <= '0;
      mul_q  <= (op == OP_MUL);
      half_q <= (op == OP_DIV16);
      case (op)
        OP_DIV16: begin
          acc_q   <= {opa[15:0], 16'h0000};
          den_q   <= opb;
          iters_q <= IT_W'(IT_HALF);
        end
        OP_MUL: begin
          acc_q   <= {16'h0000, opb};
          den_q   <= opa[15:0];
          iters_q <= IT_W'(IT_HALF);
        end
        default: begin
          acc_q   <= opa;
          den_q   <= opb;
          iters_q <= IT_W'(IT_DIV32);
        end
      endcase
    end else if (iters_q != '0) begin
      acc_q   <= acc_n;
      rem_q   <= rem_n;
      iters_q <= iters_q - 1'b1;
    end
  end

  assign res_lo = half_q ? {16'h0000, acc_q[15:0]} : acc_q;
  assign res_hi = rem_q;
endmodule

// File: rtl/seqsel_mdu_shifter.sv
module seqsel_mdu_shifter (
  input  logic [31:0] value,
  input  logic        dir_right,
  input  logic [4:0]  count,
  output logic [31:0] result,
  output logic [4:0]  norm_cnt
);
  logic [5:0] lz;
  logic       hit;

  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      if (!hit) begin
        if (value[i]) hit = 1'b1;
        else          lz  = lz + 1'b1;
      end
    end
    if (!hit) lz = '0;
  end

  assign norm_cnt = lz[4:0];
  assign result   = (count == 5'd0) ? (value << lz[4:0])
                  : dir_right       ? (value >> count)
                  :                   (value << count);
endmodule

// File: rtl/seqsel_mdu.sv
module seqsel_mdu
  import seqsel_mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done
);
  logic [NUM_OPB-1:0][7:0] md_q, md_nx;
  logic                    dir_q;
  logic [4:0]              sc_q;
  logic                    wr_ok, ctrl_wr, start;
  mdu_op_e                 op, op_q;
  logic [LAT_W-1:0]        lat_q;
  logic [31:0]             operand, eng_lo, sh_res, sh_res_q;
  logic [15:0]             eng_hi;
  logic [4:0]              sh_n, sh_n_q;
  logic                    norm_q;
  int                      lat_sel;

  assign wr_ok   = wr_en && !busy;
  assign ctrl_wr = wr_ok && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    md_nx = md_q;
    if (wr_ok && (wr_addr < ADDR_W'(NUM_OPB))) md_nx[wr_addr] = wr_data;
  end

  assign operand = {md_nx[3], md_nx[2], md_nx[1], md_nx[0]};

  seqsel_mdu_decoder u_dec (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_addr(wr_addr),
    .start(start), .op(op)
  );

  seqsel_mdu_engine #(.STEPS(2)) u_eng (
    .clk(clk), .rst(rst), .load(start && (op != OP_SHIFT)), .op(op),
    .opa(operand), .opb({md_nx[5], md_nx[4]}),
    .res_lo(eng_lo), .res_hi(eng_hi)
  );

  seqsel_mdu_shifter u_shf (
    .value(operand), .dir_right(wr_data[5]), .count(wr_data[4:0]),
    .result(sh_res), .norm_cnt(sh_n)
  );

  always_comb begin
    case (op)
      OP_DIV32: lat_sel = LAT_DIV32;
      OP_DIV16: lat_sel = LAT_DIV16;
      OP_MUL:   lat_sel = LAT_MUL;
      default:  lat_sel = (wr_data[4:0] == 5'd0)
                          ? LAT_NORM + int'(sh_n >> 1)
                          : LAT_SHIFT + int'((wr_data[4:0] - 5'd1) >> 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      md_q     <= '0;
      dir_q    <= 1'b0;
      sc_q     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      lat_q    <= '0;
      op_q     <= OP_DIV32;
      sh_res_q <= '0;
      sh_n_q   <= '0;
      norm_q   <= 1'b0;
    end else begin
      md_q <= md_nx;
      if (ctrl_wr) begin
        dir_q <= wr_data[5];
        sc_q  <= wr_data[4:0];
      end
      if (start) begin
        busy     <= 1'b1;
        done     <= 1'b0;
        lat_q    <= LAT_W'(lat_sel - 1);
        op_q     <= op;
        sh_res_q <= sh_res;
        sh_n_q   <= sh_n;
        norm_q   <= (wr_data[4:0] == 5'd0);
      end else if (busy) begin
        if (lat_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          case (op_q)
            OP_SHIFT: begin
              {md_q[3], md_q[2], md_q[1], md_q[0]} <= sh_res_q;
              if (norm_q) sc_q <= sh_n_q;
            end
            OP_MUL: {md_q[3], md_q[2], md_q[1], md_q[0]} <= eng_lo;
            default: begin
              {md_q[3], md_q[2], md_q[1], md_q[0]} <= eng_lo;
              {md_q[5], md_q[4]} <= eng_hi;
            end
          endcase
        end else begin
          lat_q <= lat_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                rd_data <= '0;
    else if (rd_addr < ADDR_W'(NUM_OPB))    rd_data <= md_q[rd_addr];
    else if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_data <= {2'b00, dir_q, sc_q};
    else                                    rd_data <= '0;
  end
endmodule

// File: rtl/seqsel_mdu_checker.sv
module seqsel_mdu_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic        busy,
  input logic        done,
  input logic [47:0] md_flat
);
  logic [4:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)                      busy_run <= '0;
    else if (!busy)               busy_run <= '0;
    else if (busy_run != 5'd31)   busy_run <= busy_run + 1'b1;
  end

  // R8: flags are mutually exclusive
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R8: a launch clears the completion flag
  a_r8_launch_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done);

  // R8: the end of a job raises the completion flag
  a_r8_finish_sets: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R10: operand bytes stay still while a job runs
  a_r10_hold_when_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(md_flat));

  // R9: only a write to byte 5 or the control byte can launch a job
  a_r9_launch_source: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(wr_en && (wr_addr == 3'd5 || wr_addr == 3'd6))) |=> !busy);

  // R3: no job runs longer than the slowest latency
  a_r3_latency_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run <= 5'd18));
endmodule

bind seqsel_mdu seqsel_mdu_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .busy(busy), .done(done), .md_flat(md_q)
);

// File: tb/seqsel_mdu_bench.sv
module seqsel_mdu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, done;

  seqsel_mdu u_seqsel_mdu (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  typedef struct {
    int             start;
    int             lat;
    logic [6:0][7:0] exp;
    string          tag;
  } sb_item_t;

  sb_item_t        sb[$];
  logic [6:0][7:0] mirror = '0;
  int              cyc = 0;
  int              checks = 0;
  int              fails = 0;
  logic            done_last = 1'b0;
  logic            finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    rd_addr = 3'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    if (a < 6) mirror[a] = d;
    else if (a == 6) mirror[6] = d & 8'h3F;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_busy(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input int lat, input logic [6:0][7:0] e, input string tag);
    sb_item_t it;
    it.start = cyc; it.lat = lat; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drain(input logic [6:0][7:0] e);
    while (sb.size() != 0) @(negedge clk);
    mirror = e;
  endtask

  task automatic load32(input logic [31:0] a);
    wr(0, a[7:0]); wr(1, a[15:8]); wr(2, a[23:16]); wr(3, a[31:24]);
  endtask

  task automatic do_div32(input logic [31:0] a, input logic [15:0] b, input bit nowait);
    logic [6:0][7:0] e;
    logic [31:0] q;
    logic [15:0] r;
    load32(a); wr(4, b[7:0]); wr(5, b[15:8]);
    q = a / {16'h0, b};
    r = 16'(a % {16'h0, b});
    e = mirror;
    {e[3], e[2], e[1], e[0]} = q;
    {e[5], e[4]} = r;
    push(17, e, "R3 div32");
    if (!nowait) drain(e);
  endtask

  task automatic do_div16(input logic [15:0] a, input logic [15:0] b);
    logic [6:0][7:0] e;
    wr(0, a[7:0]); wr(1, a[15:8]); wr(4, b[7:0]); wr(5, b[15:8]);
    e = mirror;
    {e[1], e[0]} = a / b;
    e[2] = 8'h00; e[3] = 8'h00;
    {e[5], e[4]} = a % b;
    push(9, e, "R4 div16");
    drain(e);
  endtask

  task automatic do_mul(input logic [15:0] a, input logic [15:0] b);
    logic [6:0][7:0] e;
    wr(0, a[7:0]); wr(4, b[7:0]); wr(1, a[15:8]); wr(5, b[15:8]);
    e = mirror;
    {e[3], e[2], e[1], e[0]} = {16'h0, a} * {16'h0, b};
    push(11, e, "R5 mul");
    drain(e);
  endtask

  task automatic do_shift(input logic [31:0] a, input bit right, input int n);
    logic [6:0][7:0] e;
    logic [31:0] v;
    int k;
    load32(a);
    wr(6, {2'b00, right, 5'(n)});
    e = mirror;
    if (n != 0) begin
      v = right ? (a >> n) : (a << n);
      {e[3], e[2], e[1], e[0]} = v;
      push(3 + (n - 1) / 2, e, "R6 shift");
    end else begin
      v = a; k = 0;
      if (v != 0) while (!v[31]) begin v = v << 1; k++; end
      {e[3], e[2], e[1], e[0]} = v;
      e[6] = {2'b00, right, 5'(k)};
      push(4 + k / 2, e, "R7 normalize");
    end
    drain(e);
  endtask

  task automatic expect_idle(input string tag);
    logic [7:0] v;
    repeat (25) @(negedge clk);
    check(busy == 1'b0, {tag, " no launch busy"}, 32'(busy), 32'd0);
    check(done == 1'b1, {tag, " done kept"}, 32'(done), 32'd1);
    for (int i = 0; i < 7; i++) begin
      rd(i, v);
      check(v == mirror[i], {tag, " stored byte"}, 32'(v), 32'(mirror[i]));
    end
  endtask

  // scoreboard monitor
  initial begin
    logic [7:0] v;
    forever begin
      @(negedge clk);
      if (!rst && done && !done_last) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected completion", 32'(cyc), 32'd0);
        end else begin
          check(cyc == sb[0].start + sb[0].lat, {sb[0].tag, " latency"},
                32'(cyc - sb[0].start), 32'(sb[0].lat));
          for (int i = 0; i < 7; i++) begin
            rd(i, v);
            check(v == sb[0].exp[i], {sb[0].tag, " result byte"}, 32'(v),
                  32'(sb[0].exp[i]));
          end
          void'(sb.pop_front());
        end
      end
      done_last = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && done == 1'b0, "R1 flags", {30'd0, busy, done}, 32'd0);
    for (int i = 0; i < 7; i++) begin
      rd(i, v);
      check(v == 8'h00, "R1 reset byte", 32'(v), 32'd0);
    end
    // R2 map and readback, stray control write starts nothing
    wr(2, 8'h5A);
    wr(6, 8'hE5);
    rd(2, v); check(v == 8'h5A, "R2 byte readback", 32'(v), 32'h5A);
    rd(6, v); check(v == 8'h25, "R2 control readback", 32'(v), 32'h25);
    check(busy == 1'b0, "R2 no launch", 32'(busy), 32'd0);

    do_div32(32'h12345678, 16'h1234, 1'b0);
    do_div32(32'hFFFFFFFF, 16'h0001, 1'b0);
    do_div16(16'hBEEF, 16'h0123);
    do_div16(16'h0005, 16'h0009);
    do_mul(16'hFFFF, 16'hFFFF);
    do_mul(16'h1234, 16'h5678);
    do_shift(32'h80000001, 1'b0, 1);
    do_shift(32'hF0000000, 1'b1, 31);
    do_shift(32'h00C30F0F, 1'b0, 4);
    do_shift(32'h00C30F0F, 1'b1, 2);
    do_shift(32'h00001234, 1'b0, 0);
    do_shift(32'h00000000, 1'b1, 0);
    do_shift(32'h00000001, 1'b0, 0);
    do_shift(32'h80000000, 1'b0, 0);

    // R9 broken orders
    wr(0, 8'h11); wr(1, 8'h22); wr(3, 8'h33); wr(4, 8'h44); wr(5, 8'h55);
    expect_idle("R9 skip B2");
    wr(0, 8'h01); wr(1, 8'h02); wr(2, 8'h03); wr(6, 8'h05);
    expect_idle("R9 early control");
    wr(0, 8'h07); wr(4, 8'h08); wr(5, 8'h09);
    expect_idle("R9 product missing B1");
    // R9 restart on B0
    wr(0, 8'hFF); wr(1, 8'hFF); wr(0, 8'h10); do_div16(16'h2710, 16'h0007);

    // R10 writes during a job are ignored
    do_div32(32'hDEADBEEF, 16'h00FF, 1'b1);
    wr_busy(0, 8'hAA);
    wr_busy(5, 8'h00);
    wr_busy(6, 8'h3F);
    drain(sb.size() != 0 ? sb[0].exp : mirror);
    wr(4, 8'h01); wr(5, 8'h02);
    expect_idle("R10 decoder not advanced");

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R8 scoreboard empty", 32'(sb.size()), 32'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule